// File: doc/BRIEF.md
# Multi-Mode Serial Converter Host Controller

This block runs one conversion exchange at a time with an external serial analog-to-digital converter. The link has four wires: a chip select, a serial clock, a host-to-device data line and a device-to-host data line. A fifth line is a separate conversion-done strobe from the device. The user side asks for one exchange with a single-cycle request. The request carries a channel number, single-ended or differential input, unipolar or bipolar range, a 3-bit range selection and a 3-bit operating mode. The block then lowers chip select and shifts out a 12-bit command word. It completes the exchange in the way the mode requires and returns a 14-bit result with a one-cycle valid pulse.

The serial clock idles low. The host changes its output after each falling edge and samples the device on each rising edge. In external-clock mode the host supplies a fixed number of extra clocks for the conversion and ignores the strobe. In external-acquisition and internal-clock modes the host parks the serial clock low and waits for a rising strobe, which has a timeout. The reset and power-down commands send only the command word. Each mode has its own serial clock half-period, given as a number of system clock cycles, so the device's rate limit for that mode is respected.

Top module: `adc_link_ctrl`

## Requirements
- R1: After reset, cs_n is high, sclk is low, and busy, result_valid and timeout_err are all low.
- R2: A request is accepted only while busy is low. busy rises on the cycle after acceptance and stays high until the exchange ends. A request raised while busy is high has no effect on the command sent and starts no further exchange.
- R3: The command word is 12 bits and is sent MSB first on mosi. Bit 11 is a constant 1. Bits 10:8 hold the channel, bit 7 is 1 for differential, bit 6 is 1 for bipolar, bits 5:3 hold the range selection and bits 2:0 hold the mode. mosi is stable while sclk is high, and sclk idles low.
- R4: Each sclk high and low phase lasts HALF_EXT_CLK system cycles in mode 0, HALF_EXT_ACQ cycles in mode 1, and HALF_INT_CLK cycles in every other mode.
- R5: In mode 0, the command is followed by CONV_CLKS further sclk periods and then by 14 read periods. The strobe input is ignored. result_valid rises 2·HALF_EXT_CLK·(12+CONV_CLKS+14) cycles after the accepting edge.
- R6: In modes 1 and 2, after the command, sclk stays low and cs_n stays low until the strobe rises. The 14 read periods follow, for 26 rising sclk edges in total.
- R7: The result is taken from miso on rising sclk edges, MSB first. It appears on result together with a one-cycle result_valid pulse. cs_n rises and busy falls in that same cycle.
- R8: If the strobe does not rise within TIMEOUT cycles of the end of the command, timeout_err pulses for one cycle TIMEOUT cycles after that point. At the same time cs_n rises and busy falls, with no result_valid. A later request runs normally.
- R9: Modes 3 through 7 (reset and the two power-down commands among them) send only the 12-bit command. busy then falls with no result_valid and no timeout_err.
- R10: Whenever cs_n is high, sclk is low. cs_n is high between exchanges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start an exchange (taken when idle) |
| req_chan | input | 3 | Channel number |
| req_diff | input | 1 | 1 = differential input |
| req_bipolar | input | 1 | 1 = bipolar range |
| req_range | input | 3 | Range selection field |
| req_mode | input | 3 | Operating mode code |
| busy | output | 1 | Exchange in progress |
| result | output | 14 | Last conversion result |
| result_valid | output | 1 | One-cycle result strobe |
| timeout_err | output | 1 | One-cycle strobe timeout flag |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Command data to device |
| miso | input | 1 | Result data from device (high impedance when deselected) |
| strobe | input | 1 | Conversion-done strobe from device |

## Verification
A wrong mode decode or a wrong divider load shows up within the first sclk phase. The measured high time differs, and the rising-edge count at chip-select release becomes 12, 26 or 30 where another value was due. A stuck bit counter shows as a mode-0 latency that differs from its exact figure. A state that fails to park shows as sclk edges counted before the strobe. A wrong timeout count moves the error pulse away from its exact cycle. A corrupted shift path shows as a wrong result or command word on the first exchange that has a differing bit.

// File: rtl/adc_link_ctrl.sv
module adc_link_ctrl #(
  parameter int RES_W        = 14,
  parameter int CONV_CLKS    = 4,
  parameter int HALF_EXT_CLK = 7,
  parameter int HALF_EXT_ACQ = 6,
  parameter int HALF_INT_CLK = 3,
  parameter int TIMEOUT      = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [2:0]       req_chan,
  input  logic             req_diff,
  input  logic             req_bipolar,
  input  logic [2:0]       req_range,
  input  logic [2:0]       req_mode,
  output logic             busy,
  output logic [RES_W-1:0] result,
  output logic             result_valid,
  output logic             timeout_err,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso,
  input  logic             strobe
);
  localparam int CMD_W = 12;
  localparam int HMAX  = (HALF_EXT_CLK > HALF_EXT_ACQ) ?
                         ((HALF_EXT_CLK > HALF_INT_CLK) ? HALF_EXT_CLK : HALF_INT_CLK) :
                         ((HALF_EXT_ACQ > HALF_INT_CLK) ? HALF_EXT_ACQ : HALF_INT_CLK);
  localparam int HW    = $clog2(HMAX + 1);
  localparam int BMAX  = (CMD_W > RES_W) ? ((CMD_W > CONV_CLKS) ? CMD_W : CONV_CLKS)
                                         : ((RES_W > CONV_CLKS) ? RES_W : CONV_CLKS);
  localparam int BW    = $clog2(BMAX + 1);
  localparam int TW    = $clog2(TIMEOUT + 1);

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_CONV, S_WAIT, S_READ} st_t;

  st_t              st;
  logic [CMD_W-1:0] cmd_sh;
  logic [2:0]       mode_q;
  logic [HW-1:0]    half_q, div_cnt;
  logic [BW-1:0]    bit_cnt, bit_last;
  logic [TW-1:0]    tcnt;
  logic [RES_W-1:0] sh;
  logic             strobe_q;
  logic [HW-1:0]    half_req;

  assign busy     = (st != S_IDLE);
  assign mosi     = cmd_sh[CMD_W-1];
  assign half_req = (req_mode == 3'd0) ? HW'(HALF_EXT_CLK) :
                    (req_mode == 3'd1) ? HW'(HALF_EXT_ACQ) : HW'(HALF_INT_CLK);
  assign bit_last = (st == S_SEND) ? BW'(CMD_W - 1) :
                    (st == S_CONV) ? BW'(CONV_CLKS - 1) : BW'(RES_W - 1);

  wire shifting = (st == S_SEND) || (st == S_CONV) || (st == S_READ);
  wire tick     = shifting && (div_cnt + HW'(1) == half_q);
  wire rise_e   = tick && !sclk;
  wire fall_e   = tick && sclk;
  wire last_bit = (bit_cnt == bit_last);
  wire strobe_up = strobe && !strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cmd_sh <= '0; mode_q <= '0; half_q <= HW'(HALF_INT_CLK);
      div_cnt <= '0; bit_cnt <= '0; tcnt <= '0; sh <= '0; strobe_q <= 1'b0;
      sclk <= 1'b0; cs_n <= 1'b1; result <= '0; result_valid <= 1'b0; timeout_err <= 1'b0;
    end else begin
      strobe_q     <= strobe;
      result_valid <= 1'b0;
      timeout_err  <= 1'b0;
      if (shifting) begin
        div_cnt <= tick ? '0 : div_cnt + HW'(1);
        if (tick) sclk <= ~sclk;
      end
      if (rise_e && st == S_READ) sh <= {sh[RES_W-2:0], miso};
      if (fall_e) bit_cnt <= last_bit ? '0 : bit_cnt + BW'(1);
      unique case (st)
        S_IDLE: if (req) begin
          cmd_sh  <= {1'b1, req_chan, req_diff, req_bipolar, req_range, req_mode};
          mode_q  <= req_mode;
          half_q  <= half_req;
          div_cnt <= '0;
          bit_cnt <= '0;
          sclk    <= 1'b0;
          cs_n    <= 1'b0;
          st      <= S_SEND;
        end
        S_SEND: if (fall_e) begin
          cmd_sh <= {cmd_sh[CMD_W-2:0], 1'b0};
          if (last_bit) begin
            if (mode_q == 3'd0) st <= S_CONV;
            else if (mode_q == 3'd1 || mode_q == 3'd2) begin
              st <= S_WAIT; tcnt <= '0;
            end else begin
              st <= S_IDLE; cs_n <= 1'b1;
            end
          end
        end
        S_CONV: if (fall_e && last_bit) st <= S_READ;
        S_WAIT: begin
          tcnt <= tcnt + TW'(1);
          if (strobe_up) begin
            st <= S_READ; div_cnt <= '0;
          end else if (tcnt == TW'(TIMEOUT - 1)) begin
            st <= S_IDLE; cs_n <= 1'b1; timeout_err <= 1'b1;
          end
        end
        S_READ: if (fall_e && last_bit) begin
          st <= S_IDLE; cs_n <= 1'b1; result <= sh; result_valid <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r10_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  a_r3_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  a_r2_cfg_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q));
  a_r6_parked_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> (!sclk && !cs_n && (mode_q == 3'd1 || mode_q == 3'd2)));
  a_r7_valid_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (cs_n && !busy && !timeout_err));
  a_r8_err_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (cs_n && !busy && $past(st == S_WAIT)));
endmodule

// File: tb/adc_link_ctrl_tb.sv
module adc_link_ctrl_tb;
  localparam int CONV = 4;
  localparam int HX = 7, HA = 6, HI = 3;
  localparam int TMO = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_diff = 1'b0, req_bipolar = 1'b0, strobe = 1'b0;
  logic [2:0] req_chan = '0, req_range = '0, req_mode = '0;
  logic busy, result_valid, timeout_err, sclk, cs_n, mosi;
  logic [13:0] result;
  tri miso;

  always #10 clk = ~clk;

  adc_link_ctrl #(.RES_W(14), .CONV_CLKS(CONV), .HALF_EXT_CLK(HX), .HALF_EXT_ACQ(HA),
                  .HALF_INT_CLK(HI), .TIMEOUT(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_chan(req_chan), .req_diff(req_diff),
    .req_bipolar(req_bipolar), .req_range(req_range), .req_mode(req_mode), .busy(busy),
    .result(result), .result_valid(result_valid), .timeout_err(timeout_err), .sclk(sclk),
    .cs_n(cs_n), .mosi(mosi), .miso(miso), .strobe(strobe));

  int checks = 0, fails = 0;
  logic [13:0] dev_data = '0;
  logic [11:0] cmd_cap = '0, cmd_last = '0;
  int rcnt = 0, last_rcnt = 0, nfall = 0;
  logic dbit;

  always @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      last_rcnt <= rcnt; cmd_last <= cmd_cap; rcnt <= 0;
    end else begin
      if (rcnt < 12) cmd_cap <= {cmd_cap[10:0], mosi};
      rcnt <= rcnt + 1;
    end
  end

  always @(negedge sclk or posedge cs_n)
    if (cs_n) nfall <= 0; else nfall <= nfall + 1;

  always_comb begin
    int idx;
    idx = nfall - (12 + ((rcnt >= 12 && cmd_cap[2:0] == 3'd0) ? CONV : 0));
    dbit = (idx >= 0 && idx < 14) ? dev_data[13 - idx] : 1'b0;
  end
  assign miso = cs_n ? 1'bz : dbit;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int r_lat, r_hi;
  bit r_v, r_e, r_viol;
  logic [13:0] r_res;

  task automatic run(input logic [2:0] md, input logic [2:0] ch, input logic [2:0] rg,
                     input logic dv, input logic bp, input int sdel, input bit poke);
    int cnt; bit fired, hidone;
    dev_data = 14'((int'(ch) * 1373 + int'(md) * 911 + int'(dv) * 57 + int'(bp) * 3 + 5) & 16'h3fff);
    cnt = sdel; fired = 0; hidone = 0; r_hi = 0; r_viol = 0;
    @(negedge clk);
    req_mode = md; req_chan = ch; req_range = rg; req_diff = dv; req_bipolar = bp; req = 1'b1;
    @(negedge clk);
    req = 1'b0; r_lat = 1;
    while (busy && r_lat < 20000) begin
      if (sclk && !hidone) r_hi++;
      else if (!sclk && r_hi > 0) hidone = 1;
      if (poke && r_lat == 8) begin
        req = 1'b1; req_chan = ~ch; req_mode = 3'd7; req_range = ~rg;
      end else req = 1'b0;
      if (sdel >= 0 && !fired && nfall >= 12) begin
        if (cnt == 0) begin strobe = 1'b1; fired = 1; end else cnt--;
      end
      if ((md == 3'd1 || md == 3'd2) && !fired && nfall > 12) r_viol = 1;
      @(negedge clk);
      r_lat++;
    end
    req = 1'b0;
    r_v = result_valid; r_e = timeout_err; r_res = result;
    repeat (3) @(negedge clk);
    strobe = 1'b0;
  endtask

  function automatic logic [11:0] cmd_of(input logic [2:0] md, input logic [2:0] ch,
                                         input logic [2:0] rg, input logic dv, input logic bp);
    return {1'b1, ch, dv, bp, rg, md};
  endfunction

  task automatic check_read(input logic [2:0] md, input logic [2:0] ch, input logic [2:0] rg,
                            input logic dv, input logic bp, input int h, input int rexp);
    chk(r_v && !r_e, "R7 valid pulse", int'(r_v), 1);
    chk(r_res == dev_data, "R7 result", int'(r_res), int'(dev_data));
    chk(cmd_last == cmd_of(md, ch, rg, dv, bp), "R3 command word", int'(cmd_last),
        int'(cmd_of(md, ch, rg, dv, bp)));
    chk(last_rcnt == rexp, "R6 rising edge count", last_rcnt, rexp);
    chk(r_hi == h, "R4 sclk high phase", r_hi, h);
    chk(cs_n && !sclk, "R10 idle lines", int'({cs_n, sclk}), 2);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !busy && !result_valid && !timeout_err, "R1 reset state",
        int'({cs_n, sclk, busy, result_valid, timeout_err}), 16);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !sclk && !busy, "R1 after release", int'({cs_n, sclk, busy}), 4);

    for (int c = 0; c < 8; c++)
      for (int d = 0; d < 2; d++)
        for (int b = 0; b < 2; b++) begin
          run(3'd2, 3'(c), 3'(c ^ 3), 1'(d), 1'(b), c * 3 + d, 1'b0);
          check_read(3'd2, 3'(c), 3'(c ^ 3), 1'(d), 1'(b), HI, 26);
          chk(!r_viol, "R6 no sclk before strobe", int'(r_viol), 0);
        end

    for (int c = 0; c < 8; c++) begin
      run(3'd1, 3'(c), 3'(7 - c), c[0], c[1], 2 + c, 1'b0);
      check_read(3'd1, 3'(c), 3'(7 - c), c[0], c[1], HA, 26);
      chk(!r_viol, "R6 no sclk before strobe", int'(r_viol), 0);
    end

    for (int c = 0; c < 8; c++) begin
      run(3'd0, 3'(c), 3'(c), c[1], c[0], c[0] ? 1 : -1, 1'b0);
      check_read(3'd0, 3'(c), 3'(c), c[1], c[0], HX, 12 + CONV + 14);
      chk(r_lat == 1 + 2 * HX * (12 + CONV + 14), "R5 mode0 latency, strobe ignored",
          r_lat, 1 + 2 * HX * (12 + CONV + 14));
    end

    for (int m = 3; m < 8; m++) begin
      run(3'(m), 3'(m), 3'd2, 1'b1, 1'b0, -1, 1'b0);
      chk(!r_v && !r_e, "R9 no result phase", int'({r_v, r_e}), 0);
      chk(last_rcnt == 12, "R9 command only", last_rcnt, 12);
      chk(r_lat == 1 + 2 * HI * 12, "R9 control latency", r_lat, 1 + 2 * HI * 12);
      chk(cmd_last == cmd_of(3'(m), 3'(m), 3'd2, 1'b1, 1'b0), "R3 control command",
          int'(cmd_last), int'(cmd_of(3'(m), 3'(m), 3'd2, 1'b1, 1'b0)));
      chk(r_hi == HI, "R4 control sclk phase", r_hi, HI);
    end

    run(3'd2, 3'd6, 3'd1, 1'b0, 1'b1, -1, 1'b0);
    chk(r_e && !r_v, "R8 timeout flag", int'({r_e, r_v}), 2);
    chk(r_lat == 1 + 2 * HI * 12 + TMO, "R8 timeout latency", r_lat, 1 + 2 * HI * 12 + TMO);
    chk(last_rcnt == 12, "R8 no read", last_rcnt, 12);
    run(3'd1, 3'd3, 3'd4, 1'b1, 1'b1, -1, 1'b0);
    chk(r_e && !r_v, "R8 timeout flag mode1", int'({r_e, r_v}), 2);
    chk(r_lat == 1 + 2 * HA * 12 + TMO, "R8 timeout latency mode1", r_lat, 1 + 2 * HA * 12 + TMO);
    run(3'd2, 3'd1, 3'd5, 1'b1, 1'b0, 4, 1'b0);
    check_read(3'd2, 3'd1, 3'd5, 1'b1, 1'b0, HI, 26);
    chk(!r_e, "R8 recovery after timeout", int'(r_e), 0);

    run(3'd1, 3'd5, 3'd2, 1'b0, 1'b1, 3, 1'b1);
    check_read(3'd1, 3'd5, 3'd2, 1'b0, 1'b1, HA, 26);
    repeat (4) @(negedge clk);
    chk(!busy && cs_n, "R2 request while busy ignored", int'({busy, cs_n}), 1);
    run(3'd0, 3'd2, 3'd6, 1'b1, 1'b1, -1, 1'b1);
    chk(cmd_last == cmd_of(3'd0, 3'd2, 3'd6, 1'b1, 1'b1), "R2 command unchanged by busy request",
        int'(cmd_last), int'(cmd_of(3'd0, 3'd2, 3'd6, 1'b1, 1'b1)));
    chk(r_lat == 1 + 2 * HX * (12 + CONV + 14), "R2 busy span", r_lat, 1 + 2 * HX * (12 + CONV + 14));
    repeat (4) @(negedge clk);
    chk(!busy && cs_n && !sclk, "R10 no extra exchange", int'({busy, cs_n, sclk}), 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule